// File: doc/BRIEF.md
# SPI Packet Buffer Port

This block is an SPI slave that lets a host processor reach the 128-byte packet buffer of a radio transceiver. An access begins when chip select goes low. The first byte the host sends is a command byte, and the slave returns a status byte on MISO in the same eight clocks. The command byte picks a read burst or a write burst.

A read burst returns the length field and then the payload. Three trailing bytes follow: link quality, energy detect and receive status. A write burst takes the length field and then the payload, and places them in the buffer starting at offset 0. A byte index restarts on every new selection, and the buffer offset is derived from it. For this reason any access may stop at any byte without harm.

The SPI pins are sampled with the system clock. SPI mode 0 is used, MSB first. Each SCLK high phase and each low phase must last at least four system clock cycles. The buffer RAM lies outside the block and has a one-cycle registered read. Neither side can apply back-pressure. The SPI master cannot be stalled, and the buffer write port accepts one byte per cycle with no ready signal, so there is no valid/ready pair at either edge.

Top module: `fbuf_spi_slave`

## Requirements
- R1: Command byte 0x20 opens a read burst and 0x60 opens a write burst. Any other first byte is ignored until chip select rises: every MISO byte after the status byte is 0x00, and the buffer is never written.
- R2: SPI mode 0, MSB first. The first MISO byte is the value of `phy_status` at the falling edge of chip select, and it is shifted out while the command byte is shifted in.
- R3: A read burst returns, in order: the status byte, the length L (buffer offset 0 with bit 7 forced to 0), buffer offsets 1..L, link quality, energy detect and receive status. That is 5 + L bytes.
- R4: The receive status byte is {crc_ok, trac[2:0], 4'b0000}: bit 7 is the CRC flag, bits 6:4 are the transaction code, and bits 3:0 read as zero.
- R5: Every read byte after byte 5 + L is 0x00.
- R6: Link quality, energy detect, CRC flag and transaction code are captured when the read command is decoded. Later changes on those inputs do not affect the current burst.
- R7: In a write burst the second byte is the length. It is stored at offset 0 with bit 7 cleared, and only bits 6:0 set L. Payload byte i (1..L) goes to offset i.
- R8: A write burst performs exactly L + 1 buffer writes. Bytes after byte 2 + L are discarded.
- R9: Releasing chip select at any byte ends the access. The next access restarts at the command byte and reads or writes the length at offset 0. Earlier buffer contents are left unchanged.
- R10: While chip select is high, MISO is 0 and SCLK/MOSI activity causes no buffer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-free reset, sampled on clk |
| spi_sclk | input | 1 | SPI clock from the host, idle low |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_csn | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Slave-to-host serial data |
| phy_status | input | 8 | Status byte returned during the command byte |
| lqi_in | input | 8 | Link quality of the last received frame |
| ed_in | input | 8 | Energy detect level |
| crc_ok_in | input | 1 | CRC check result of the last received frame |
| trac_in | input | 3 | Transaction status code |
| ram_raddr | output | 7 | Buffer read offset |
| ram_rdata | input | 8 | Buffer read data, valid one clk after ram_raddr |
| ram_we | output | 1 | Buffer write strobe, one clk per byte |
| ram_waddr | output | 7 | Buffer write offset |
| ram_wdata | output | 8 | Buffer write data |

## Verification
Each SCLK edge takes three clk cycles to reach the byte logic: two synchronizer stages and one edge-detect stage. After the eighth rising edge of a byte, the next MISO byte is ready about four clk cycles later and is loaded on the following falling SCLK edge. The bench samples MISO when it raises SCLK, a full half-period of eight clk cycles after that load. The buffer write for a received byte appears on the RAM port about four clk cycles after that byte's last rising edge. The bench counts write strobes and judges R1, R8 and R10 only after chip select has been high for eight clk cycles, so every strobe due from the burst has already landed.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_DROP  = 2'd3
  } acc_t;

  localparam logic [7:0] OP_READ  = 8'h20;
  localparam logic [7:0] OP_WRITE = 8'h60;
endpackage

// File: rtl/fbuf_edge_sync.sv
// Brings SCLK, MOSI and chip select into the clk domain and flags SCLK edges.
module fbuf_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic mosi,
  input  logic csn,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic mosi_q,
  output logic sel_on,
  output logic sel_start
);
  logic [SYNC_STAGES:0]   sck_p;
  logic [SYNC_STAGES:0]   cs_p;
  logic [SYNC_STAGES-1:0] mo_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_p <= '0;
      cs_p  <= '1;
      mo_p  <= '0;
    end else begin
      sck_p <= {sck_p[SYNC_STAGES-1:0], sclk};
      cs_p  <= {cs_p[SYNC_STAGES-1:0], csn};
      mo_p  <= {mo_p[SYNC_STAGES-2:0], mosi};
    end
  end

  assign mosi_q    = mo_p[SYNC_STAGES-1];
  assign sel_on    = !cs_p[SYNC_STAGES-1];
  assign sel_start = !cs_p[SYNC_STAGES-1] && cs_p[SYNC_STAGES];
  assign sclk_rise = sel_on &&  sck_p[SYNC_STAGES-1] && !sck_p[SYNC_STAGES];
  assign sclk_fall = sel_on && !sck_p[SYNC_STAGES-1] &&  sck_p[SYNC_STAGES];
endmodule

// File: rtl/fbuf_shifter.sv
// Byte framing: MOSI sampled on rising SCLK, MISO updated on falling SCLK.
module fbuf_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_on,
  input  logic       sel_start,
  input  logic       rise,
  input  logic       fall,
  input  logic       mosi,
  input  logic [7:0] first_byte,
  input  logic [7:0] next_byte,
  output logic       miso,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      byte_done <= 1'b0;
      rx_byte   <= '0;
    end else begin
      byte_done <= 1'b0;
      if (!sel_on) begin
        bit_cnt <= '0;
        tx_sh   <= '0;
      end else if (sel_start) begin
        bit_cnt <= '0;
        tx_sh   <= first_byte;
      end else begin
        if (rise) begin
          rx_sh   <= {rx_sh[6:0], mosi};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_done <= 1'b1;
            rx_byte   <= {rx_sh[6:0], mosi};
          end
        end
        if (fall) begin
          tx_sh <= (bit_cnt == 3'd0) ? next_byte : {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  assign miso = tx_sh[7];

  // R2: a completed byte is always the result of a detected rising SCLK edge
  p_done_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(rise));

  // R10: MISO falls quiet once the slave is deselected
  p_quiet_when_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_on |=> !miso);
endmodule

// File: rtl/fbuf_seq.sv
// Access sequencer: command decode, byte index, buffer offsets, MISO byte select.
module fbuf_seq
  import fbuf_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_on,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  input  logic [7:0]        lqi_in,
  input  logic [7:0]        ed_in,
  input  logic              crc_ok_in,
  input  logic [2:0]        trac_in,
  input  logic [7:0]        ram_rdata,
  output logic [7:0]        next_byte,
  output logic [ADDR_W-1:0] ram_raddr,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [7:0]        ram_wdata
);
  localparam int              IDX_W    = ADDR_W + 2;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [7:0]      LEN_MASK = 8'((1 << ADDR_W) - 1);

  acc_t              mode;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] len;
  logic [7:0]        sh_lqi, sh_ed, sh_stat;
  logic [IDX_W-1:0]  len_x;
  logic [IDX_W-1:0]  idx_m1;

  assign len_x     = IDX_W'(len);
  assign idx_m1    = idx - IDX_W'(1);
  assign ram_raddr = idx_m1[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= ACC_IDLE;
      idx       <= '0;
      len       <= '0;
      sh_lqi    <= '0;
      sh_ed     <= '0;
      sh_stat   <= '0;
      ram_we    <= 1'b0;
      ram_waddr <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= 1'b0;
      if (!sel_on) begin
        mode <= ACC_IDLE;
        idx  <= '0;
      end else if (byte_done) begin
        if (idx != IDX_MAX) idx <= idx + IDX_W'(1);
        if (idx == '0) begin
          case (rx_byte)
            OP_READ: begin
              mode    <= ACC_READ;
              sh_lqi  <= lqi_in;
              sh_ed   <= ed_in;
              sh_stat <= {crc_ok_in, trac_in, 4'b0000};
            end
            OP_WRITE: mode <= ACC_WRITE;
            default:  mode <= ACC_DROP;
          endcase
        end else if (mode == ACC_READ && idx == IDX_W'(1)) begin
          len <= ram_rdata[ADDR_W-1:0];
        end else if (mode == ACC_WRITE) begin
          if (idx == IDX_W'(1)) begin
            len       <= rx_byte[ADDR_W-1:0];
            ram_we    <= 1'b1;
            ram_waddr <= '0;
            ram_wdata <= rx_byte & LEN_MASK;
          end else if (idx <= len_x + IDX_W'(1)) begin
            ram_we    <= 1'b1;
            ram_waddr <= idx_m1[ADDR_W-1:0];
            ram_wdata <= rx_byte;
          end
        end
      end
    end
  end

  always_comb begin
    next_byte = 8'h00;
    if (mode == ACC_READ) begin
      if (idx == IDX_W'(1))                              next_byte = ram_rdata & LEN_MASK;
      else if (idx >= IDX_W'(2) && idx <= len_x + IDX_W'(1)) next_byte = ram_rdata;
      else if (idx == len_x + IDX_W'(2))                 next_byte = sh_lqi;
      else if (idx == len_x + IDX_W'(3))                 next_byte = sh_ed;
      else if (idx == len_x + IDX_W'(4))                 next_byte = sh_stat;
    end
  end

  // R1: buffer writes come only from a decoded write burst
  p_write_mode_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(mode) == ACC_WRITE);

  // R8: no write lands beyond the stored length
  p_write_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_waddr <= len);

  // R7: the stored length never carries bit 7
  p_len_bit7_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_waddr == '0) |-> !ram_wdata[7]);

  // R6: trailer shadows hold for the whole read burst
  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ACC_READ && $past(mode) == ACC_READ) |->
      ($stable(sh_lqi) && $stable(sh_ed) && $stable(sh_stat)));

  // R9: deselection restarts the byte index
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_on |=> idx == '0);
endmodule

// File: rtl/fbuf_spi_slave.sv
module fbuf_spi_slave #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_csn,
  output logic              spi_miso,
  input  logic [7:0]        phy_status,
  input  logic [7:0]        lqi_in,
  input  logic [7:0]        ed_in,
  input  logic              crc_ok_in,
  input  logic [2:0]        trac_in,
  output logic [ADDR_W-1:0] ram_raddr,
  input  logic [7:0]        ram_rdata,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [7:0]        ram_wdata
);
  logic       rise, fall, mosi_q, sel_on, sel_start;
  logic       byte_done;
  logic [7:0] rx_byte, next_byte;

  fbuf_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk(spi_sclk), .mosi(spi_mosi), .csn(spi_csn),
    .sclk_rise(rise), .sclk_fall(fall), .mosi_q(mosi_q),
    .sel_on(sel_on), .sel_start(sel_start)
  );

  fbuf_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_on(sel_on), .sel_start(sel_start),
    .rise(rise), .fall(fall), .mosi(mosi_q),
    .first_byte(phy_status), .next_byte(next_byte),
    .miso(spi_miso), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  fbuf_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sel_on(sel_on), .byte_done(byte_done), .rx_byte(rx_byte),
    .lqi_in(lqi_in), .ed_in(ed_in), .crc_ok_in(crc_ok_in), .trac_in(trac_in),
    .ram_rdata(ram_rdata), .next_byte(next_byte),
    .ram_raddr(ram_raddr), .ram_we(ram_we),
    .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );
endmodule

// File: tb/sim_fbuf_spi_slave.sv
`timescale 1ns/1ps
module sim_fbuf_spi_slave;
  localparam int HALF = 8;

  typedef struct packed {
    logic [7:0] len_byte;
    logic [7:0] seed;
    logic [7:0] lqi;
    logic [7:0] ed;
    logic       crc;
    logic [2:0] trac;
    logic [7:0] pst;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{8'd3,   8'h10, 8'hA5, 8'h3C, 1'b1, 3'd5, 8'h81},
    '{8'd0,   8'h20, 8'h11, 8'hF0, 1'b0, 3'd2, 8'h5A},
    '{8'd1,   8'h7E, 8'hFF, 8'h00, 1'b1, 3'd7, 8'hC3},
    '{8'h85,  8'h30, 8'h42, 8'h99, 1'b0, 3'd1, 8'h0F},
    '{8'd127, 8'h01, 8'h6D, 8'h2B, 1'b1, 3'd3, 8'hE7}
  };

  logic       clk = 0, rst_n = 0;
  logic       spi_sclk = 0, spi_mosi = 0, spi_csn = 1;
  logic       spi_miso;
  logic [7:0] phy_status = 0, lqi_in = 0, ed_in = 0;
  logic       crc_ok_in = 0;
  logic [2:0] trac_in = 0;
  logic [6:0] ram_raddr, ram_waddr;
  logic [7:0] ram_rdata, ram_wdata;
  logic       ram_we;
  logic [7:0] mem [128];
  int         we_cnt = 0;
  int         n_chk = 0, n_err = 0;
  bit         wd_hit = 0;

  always #2.5 clk = ~clk;

  fbuf_spi_slave u0 (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_csn(spi_csn), .spi_miso(spi_miso),
    .phy_status(phy_status), .lqi_in(lqi_in), .ed_in(ed_in),
    .crc_ok_in(crc_ok_in), .trac_in(trac_in),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  always @(posedge clk) begin
    if (ram_we) begin
      mem[ram_waddr] <= ram_wdata;
      we_cnt <= we_cnt + 1;
    end
    ram_rdata <= mem[ram_raddr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cs_begin();
    @(negedge clk) spi_csn = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    spi_csn = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      spi_mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = spi_miso;
      spi_sclk = 1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 0;
    end
  endtask

  task automatic write_vec(input vec_t v);
    logic [7:0] r;
    int L, w0;
    L  = int'(v.len_byte & 8'h7F);
    w0 = we_cnt;
    cs_begin();
    xfer(8'h60, r);
    xfer(v.len_byte, r);
    for (int i = 1; i <= L; i++) xfer(8'(v.seed + i), r);
    xfer(8'hEE, r);
    xfer(8'hEE, r);
    cs_end();
    chk("R8 write count", we_cnt - w0, L + 1);
  endtask

  task automatic read_vec(input vec_t v);
    logic [7:0] r;
    int L;
    L = int'(v.len_byte & 8'h7F);
    phy_status = v.pst; lqi_in = v.lqi; ed_in = v.ed;
    crc_ok_in = v.crc; trac_in = v.trac;
    cs_begin();
    xfer(8'h20, r);
    chk("R2 status byte", r, v.pst);
    lqi_in = ~v.lqi; ed_in = ~v.ed; crc_ok_in = ~v.crc; trac_in = ~v.trac;
    xfer(8'h00, r);
    chk("R3 R7 length field", r, 8'(L));
    for (int i = 1; i <= L; i++) begin
      xfer(8'h00, r);
      chk("R3 R7 payload", r, 8'(v.seed + i));
    end
    xfer(8'h00, r); chk("R6 link quality", r, v.lqi);
    xfer(8'h00, r); chk("R6 energy detect", r, v.ed);
    xfer(8'h00, r); chk("R4 receive status", r, {v.crc, v.trac, 4'b0000});
    xfer(8'h00, r); chk("R5 past end", r, 8'h00);
    xfer(8'h00, r); chk("R5 past end", r, 8'h00);
    cs_end();
  endtask

  task automatic run_all();
    logic [7:0] r;
    int w0;
    repeat (10) @(negedge clk);
    chk("R10 reset miso", spi_miso, 1'b0);
    chk("R10 reset write strobe", ram_we, 1'b0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // table of vectors: write a frame, then read it back with its trailer
    for (int k = 0; k < NV; k++) begin
      write_vec(VECS[k]);
      read_vec(VECS[k]);
    end

    // R10: bus activity while deselected
    w0 = we_cnt;
    xfer(8'h60, r); chk("R10 miso while deselected", r, 8'h00);
    xfer(8'h03, r); chk("R10 miso while deselected", r, 8'h00);
    repeat (HALF) @(negedge clk);
    chk("R10 no write while deselected", we_cnt - w0, 0);

    // R1: unknown command, followed by bytes that look like a write
    phy_status = 8'h3D;
    w0 = we_cnt;
    cs_begin();
    xfer(8'h33, r); chk("R2 status on bad command", r, 8'h3D);
    xfer(8'h60, r); chk("R1 ignored command miso", r, 8'h00);
    xfer(8'h05, r); chk("R1 ignored command miso", r, 8'h00);
    xfer(8'hAA, r); chk("R1 ignored command miso", r, 8'h00);
    cs_end();
    chk("R1 ignored command no write", we_cnt - w0, 0);

    // R9: aborted read, then a fresh read restarts at the length field
    write_vec('{8'd4, 8'h40, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00});
    cs_begin();
    xfer(8'h20, r);
    xfer(8'h00, r); chk("R9 length before abort", r, 8'd4);
    cs_end();
    cs_begin();
    xfer(8'h20, r);
    xfer(8'h00, r); chk("R9 length after abort", r, 8'd4);
    xfer(8'h00, r); chk("R9 first payload after abort", r, 8'h41);
    cs_end();

    // R9: aborted write after the length byte touches offset 0 only
    w0 = we_cnt;
    cs_begin();
    xfer(8'h60, r);
    xfer(8'h02, r);
    cs_end();
    chk("R9 aborted write count", we_cnt - w0, 1);
    cs_begin();
    xfer(8'h20, r);
    xfer(8'h00, r); chk("R9 new length", r, 8'd2);
    xfer(8'h00, r); chk("R9 payload kept", r, 8'h41);
    xfer(8'h00, r); chk("R9 payload kept", r, 8'h42);
    cs_end();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (180000) @(posedge clk);
        wd_hit = 1;
      end
    join_any
    if (wd_hit) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule